// File: doc/BRIEF.md
# Matrix Tile Configuration Controller

This block holds the shape configuration for a bank of two-dimensional tile registers. Software hands it a 512-bit configuration image that carries a palette selector and, for each of eight tiles, a row count and a bytes-per-row value. The controller checks the image. If the image is rejected, it flags a fault and keeps the previous configuration. If the image is accepted, it latches the per-tile shapes and presents them to the compute units downstream.

A store request returns the active configuration as a 512-bit image. An all-zero image comes back when nothing is configured. A release request, or a load whose palette is zero, returns the controller to the init state and pulses a zero-all strobe toward the tile data storage. All requests complete in one clock. A single-cycle done pulse marks completion, and on a rejected load a fault pulse accompanies it.

Top module: `tile_cfg_ctrl`

## Requirements
- R1: Image layout, with byte b at bits [8b+7:8b]: byte 0 holds the palette. Bytes 16+2t and 17+2t hold the bytes-per-row of tile t (0..7), little-endian. Byte 48+t holds the row count of tile t. Every other byte is reserved.
- R2: A load with a valid image and a nonzero palette sets `configured`. One clock after the request it drives each tile's rows on `tile_rows_o[5t+4:5t]` and bytes-per-row on `tile_bpr_o[7t+6:7t]`, with `op_done`=1 and `op_fault`=0.
- R3: A load is rejected with `op_fault`=1 in the same cycle as `op_done` if any of these holds: the palette is above 1, a row count is above 16, a bytes-per-row is above 64 or not a multiple of 4, a reserved byte is nonzero, or exactly one of a tile's row count and bytes-per-row is zero. A palette of 0 is never rejected.
- R4: A rejected load leaves `configured`, the tile shapes and the palette unchanged.
- R5: A load with palette 0 clears the configuration, drops `configured` and pulses `zero_all` for one cycle.
- R6: A store loads `store_image` with the canonical image of the active configuration, or with all zeros when not configured. `store_image` holds that value until the next store.
- R7: A release clears the configuration, drops `configured`, and pulses `zero_all` and `op_done` for one cycle.
- R8: When requests coincide, release wins over load and load wins over store. The losing requests have no effect.
- R9: Under reset all outputs are zero. `op_done`, `op_fault` and `zero_all` are single-cycle pulses.
- R10: A tile with both fields zero is valid. The maxima of 16 rows and 64 bytes per row are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_req | input | 1 | Load the image on `load_image` |
| load_image | input | 512 | Configuration image to load |
| store_req | input | 1 | Capture the current configuration on `store_image` |
| release_req | input | 1 | Return to init state |
| store_image | output | 512 | Image captured by the last store |
| op_done | output | 1 | Request completed (one-cycle pulse) |
| op_fault | output | 1 | Load rejected (pulse alongside `op_done`) |
| configured | output | 1 | A nonzero-palette configuration is active |
| zero_all | output | 1 | Strobe that clears all tile data |
| palette_o | output | 8 | Active palette |
| tile_rows_o | output | 40 | Row count per tile, 5 bits each |
| tile_bpr_o | output | 56 | Bytes-per-row per tile, 7 bits each |

## Verification
Load images are walked from a table. The table covers shapes at the 16-row and 64-byte limits, a tile that is unused and one that is half-specified, misaligned and oversized widths, a palette that is out of range, a dirty reserved byte, and a palette of zero. Each image separates one rejection rule from the others. A store after every load shows that a rejected image leaves the previous configuration intact. Directed sequences cover release, coincident requests that check the priority order, a store made before any configuration, and that every pulse is a single cycle wide.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;
  localparam int IMG_BYTES = 64;
  localparam int IMG_W     = IMG_BYTES * 8;
  localparam int PAL_BYTE  = 0;
  localparam int BPR_BYTE  = 16;
  localparam int ROWS_BYTE = 48;
  localparam int MAX_SLOTS = 8;

  function automatic logic [IMG_W-1:0] reserved_bits(input int n_tiles);
    logic [IMG_W-1:0] m;
    m = '1;
    m[PAL_BYTE*8 +: 8] = '0;
    for (int t = 0; t < n_tiles; t++) begin
      m[(BPR_BYTE + 2*t)*8 +: 16] = '0;
      m[(ROWS_BYTE + t)*8 +: 8]   = '0;
    end
    return m;
  endfunction
endpackage

// File: rtl/tcfg_decode.sv
module tcfg_decode #(
  parameter int NUM_TILES = 8
) (
  input  logic [tcfg_pkg::IMG_W-1:0]   image,
  output logic [7:0]                   palette,
  output logic [NUM_TILES-1:0][7:0]    rows,
  output logic [NUM_TILES-1:0][15:0]   bpr,
  output logic                         rsvd_dirty
);
  import tcfg_pkg::*;
  localparam logic [IMG_W-1:0] RSVD = reserved_bits(NUM_TILES);

  assign palette    = image[PAL_BYTE*8 +: 8];
  assign rsvd_dirty = |(image & RSVD);

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_field
    assign rows[t] = image[(ROWS_BYTE + t)*8 +: 8];
    assign bpr[t]  = image[(BPR_BYTE + 2*t)*8 +: 16];
  end
endmodule

// File: rtl/tcfg_check.sv
module tcfg_check #(
  parameter int NUM_TILES   = 8,
  parameter int MAX_ROWS    = 16,
  parameter int MAX_BPR     = 64,
  parameter int BPR_ALIGN   = 4,
  parameter int MAX_PALETTE = 1
) (
  input  logic [7:0]                 palette,
  input  logic [NUM_TILES-1:0][7:0]  rows,
  input  logic [NUM_TILES-1:0][15:0] bpr,
  input  logic                       rsvd_dirty,
  output logic                       img_ok
);
  localparam logic [7:0]  ROW_LIM    = 8'(MAX_ROWS);
  localparam logic [15:0] BPR_LIM    = 16'(MAX_BPR);
  localparam logic [15:0] ALIGN_MASK = 16'(BPR_ALIGN - 1);
  localparam logic [7:0]  PAL_LIM    = 8'(MAX_PALETTE);

  logic [NUM_TILES-1:0] tile_bad;

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
    logic rows_zero, bpr_zero;
    assign rows_zero   = (rows[t] == '0);
    assign bpr_zero    = (bpr[t] == '0);
    assign tile_bad[t] = (rows[t] > ROW_LIM)
                       | (bpr[t] > BPR_LIM)
                       | ((bpr[t] & ALIGN_MASK) != '0)
                       | (rows_zero ^ bpr_zero);
  end

  always_comb begin
    if (palette == '0) img_ok = 1'b1;
    else               img_ok = (palette <= PAL_LIM) && !rsvd_dirty && (tile_bad == '0);
  end
endmodule

// File: rtl/tcfg_encode.sv
module tcfg_encode #(
  parameter int NUM_TILES = 8,
  parameter int ROW_W     = 5,
  parameter int BPR_W     = 7
) (
  input  logic                            active,
  input  logic [7:0]                      palette,
  input  logic [NUM_TILES-1:0][ROW_W-1:0] rows,
  input  logic [NUM_TILES-1:0][BPR_W-1:0] bpr,
  output logic [tcfg_pkg::IMG_W-1:0]      image
);
  import tcfg_pkg::*;

  always_comb begin
    image = '0;
    if (active) begin
      image[PAL_BYTE*8 +: 8] = palette;
      for (int t = 0; t < NUM_TILES; t++) begin
        image[(BPR_BYTE + 2*t)*8 +: 16] = 16'(bpr[t]);
        image[(ROWS_BYTE + t)*8 +: 8]   = 8'(rows[t]);
      end
    end
  end
endmodule

// File: rtl/tile_cfg_ctrl.sv
module tile_cfg_ctrl #(
  parameter int NUM_TILES   = 8,
  parameter int MAX_ROWS    = 16,
  parameter int MAX_BPR     = 64,
  parameter int BPR_ALIGN   = 4,
  parameter int MAX_PALETTE = 1,
  localparam int ROW_W      = $clog2(MAX_ROWS + 1),
  localparam int BPR_W      = $clog2(MAX_BPR + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load_req,
  input  logic [tcfg_pkg::IMG_W-1:0]    load_image,
  input  logic                          store_req,
  input  logic                          release_req,
  output logic [tcfg_pkg::IMG_W-1:0]    store_image,
  output logic                          op_done,
  output logic                          op_fault,
  output logic                          configured,
  output logic                          zero_all,
  output logic [7:0]                    palette_o,
  output logic [NUM_TILES*ROW_W-1:0]    tile_rows_o,
  output logic [NUM_TILES*BPR_W-1:0]    tile_bpr_o
);
  import tcfg_pkg::*;

  logic [7:0]                      dec_pal;
  logic [NUM_TILES-1:0][7:0]       dec_rows;
  logic [NUM_TILES-1:0][15:0]      dec_bpr;
  logic                            dec_dirty;
  logic                            img_ok;
  logic [IMG_W-1:0]                enc_img;

  logic [7:0]                      pal_q;
  logic [NUM_TILES-1:0][ROW_W-1:0] rows_q;
  logic [NUM_TILES-1:0][BPR_W-1:0] bpr_q;
  logic                            cfg_q;

  tcfg_decode #(.NUM_TILES(NUM_TILES)) u_dec (
    .image(load_image), .palette(dec_pal), .rows(dec_rows),
    .bpr(dec_bpr), .rsvd_dirty(dec_dirty)
  );

  tcfg_check #(
    .NUM_TILES(NUM_TILES), .MAX_ROWS(MAX_ROWS), .MAX_BPR(MAX_BPR),
    .BPR_ALIGN(BPR_ALIGN), .MAX_PALETTE(MAX_PALETTE)
  ) u_chk (
    .palette(dec_pal), .rows(dec_rows), .bpr(dec_bpr),
    .rsvd_dirty(dec_dirty), .img_ok(img_ok)
  );

  tcfg_encode #(.NUM_TILES(NUM_TILES), .ROW_W(ROW_W), .BPR_W(BPR_W)) u_enc (
    .active(cfg_q), .palette(pal_q), .rows(rows_q), .bpr(bpr_q), .image(enc_img)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pal_q       <= '0;
      rows_q      <= '0;
      bpr_q       <= '0;
      cfg_q       <= 1'b0;
      store_image <= '0;
      op_done     <= 1'b0;
      op_fault    <= 1'b0;
      zero_all    <= 1'b0;
    end else begin
      op_done  <= 1'b0;
      op_fault <= 1'b0;
      zero_all <= 1'b0;
      if (release_req) begin
        pal_q    <= '0;
        rows_q   <= '0;
        bpr_q    <= '0;
        cfg_q    <= 1'b0;
        zero_all <= 1'b1;
        op_done  <= 1'b1;
      end else if (load_req) begin
        op_done <= 1'b1;
        if (!img_ok) begin
          op_fault <= 1'b1;
        end else if (dec_pal == '0) begin
          pal_q    <= '0;
          rows_q   <= '0;
          bpr_q    <= '0;
          cfg_q    <= 1'b0;
          zero_all <= 1'b1;
        end else begin
          pal_q <= dec_pal;
          cfg_q <= 1'b1;
          for (int t = 0; t < NUM_TILES; t++) begin
            rows_q[t] <= dec_rows[t][ROW_W-1:0];
            bpr_q[t]  <= dec_bpr[t][BPR_W-1:0];
          end
        end
      end else if (store_req) begin
        op_done     <= 1'b1;
        store_image <= enc_img;
      end
    end
  end

  assign configured  = cfg_q;
  assign palette_o   = pal_q;
  assign tile_rows_o = rows_q;
  assign tile_bpr_o  = bpr_q;

  // R3: a fault never appears without completion
  a_r3_fault_has_done: assert property (@(posedge clk) disable iff (rst)
    op_fault |-> op_done);

  // R4: rejected image leaves stored shape untouched
  a_r4_reject_keeps_cfg: assert property (@(posedge clk) disable iff (rst)
    op_fault |-> ($stable(rows_q) && $stable(bpr_q) && $stable(cfg_q) && $stable(pal_q)));

  // R5: zeroing strobe only when the shape state is in init
  a_r5_zero_in_init: assert property (@(posedge clk) disable iff (rst)
    zero_all |-> (!configured && rows_q == '0 && bpr_q == '0));

  // R7: a release request drops the configured flag
  a_r7_release_clears: assert property (@(posedge clk) disable iff (rst)
    (release_req && !$past(rst)) |=> (!configured && zero_all && op_done));

  // R2: latched shapes never exceed the limits
  localparam logic [ROW_W-1:0] ROWS_CAP = ROW_W'(MAX_ROWS);
  localparam logic [BPR_W-1:0] BPR_CAP  = BPR_W'(MAX_BPR);
  for (genvar t = 0; t < NUM_TILES; t++) begin : g_bound
    a_r2_shape_bounded: assert property (@(posedge clk) disable iff (rst)
      (rows_q[t] <= ROWS_CAP) && (bpr_q[t] <= BPR_CAP));
  end
endmodule

// File: tb/tile_cfg_ctrl_tb_top.sv
module tile_cfg_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] pal;
    logic [7:0] r0;
    logic [7:0] b0;
    logic [7:0] r1;
    logic [7:0] b1;
    logic       poke;
    logic       fault;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'd1, 8'd16, 8'd64, 8'd3, 8'd12, 1'b0, 1'b0},
    '{8'd2, 8'd1,  8'd4,  8'd0, 8'd0,  1'b0, 1'b1},
    '{8'd1, 8'd17, 8'd4,  8'd0, 8'd0,  1'b0, 1'b1},
    '{8'd1, 8'd4,  8'd68, 8'd0, 8'd0,  1'b0, 1'b1},
    '{8'd1, 8'd4,  8'd6,  8'd0, 8'd0,  1'b0, 1'b1},
    '{8'd1, 8'd4,  8'd0,  8'd0, 8'd0,  1'b0, 1'b1},
    '{8'd1, 8'd2,  8'd8,  8'd0, 8'd0,  1'b1, 1'b1},
    '{8'd1, 8'd0,  8'd0,  8'd1, 8'd4,  1'b0, 1'b0},
    '{8'd0, 8'd0,  8'd0,  8'd0, 8'd0,  1'b0, 1'b0},
    '{8'd1, 8'd2,  8'd8,  8'd0, 8'd0,  1'b0, 1'b0},
    '{8'd1, 8'd0,  8'd8,  8'd0, 8'd0,  1'b0, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_req = 1'b0, store_req = 1'b0, release_req = 1'b0;
  logic [511:0] load_image = '0;
  logic [511:0] store_image;
  logic         op_done, op_fault, configured, zero_all;
  logic [7:0]   palette_o;
  logic [39:0]  tile_rows_o;
  logic [55:0]  tile_bpr_o;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [511:0] exp_img = '0;
  logic         exp_cfg = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_cfg_ctrl dut_i (
    .clk(clk), .rst(rst), .load_req(load_req), .load_image(load_image),
    .store_req(store_req), .release_req(release_req), .store_image(store_image),
    .op_done(op_done), .op_fault(op_fault), .configured(configured),
    .zero_all(zero_all), .palette_o(palette_o), .tile_rows_o(tile_rows_o),
    .tile_bpr_o(tile_bpr_o)
  );

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] mk_img(input vec_t v);
    logic [511:0] m = '0;
    m[7:0]     = v.pal;
    m[128 +: 16] = {8'h00, v.b0};
    m[144 +: 16] = {8'h00, v.b1};
    m[384 +: 8]  = v.r0;
    m[392 +: 8]  = v.r1;
    if (v.poke) m[40 +: 8] = 8'h01;
    return m;
  endfunction

  task automatic pulse(input bit ld, input bit st, input bit rl, input logic [511:0] img);
    @(negedge clk);
    load_req = ld; store_req = st; release_req = rl; load_image = img;
    @(negedge clk);
    load_req = 0; store_req = 0; release_req = 0;
  endtask

  task automatic chk_shape(input string req);
    chk(tile_rows_o[4:0] == exp_img[384 +: 5], req, 512'(tile_rows_o[4:0]), 512'(exp_img[384 +: 5]));
    chk(tile_bpr_o[6:0]  == exp_img[128 +: 7], req, 512'(tile_bpr_o[6:0]), 512'(exp_img[128 +: 7]));
    chk(tile_rows_o[9:5] == exp_img[392 +: 5], req, 512'(tile_rows_o[9:5]), 512'(exp_img[392 +: 5]));
    chk(tile_bpr_o[13:7] == exp_img[144 +: 7], req, 512'(tile_bpr_o[13:7]), 512'(exp_img[144 +: 7]));
    chk(configured == exp_cfg, req, 512'(configured), 512'(exp_cfg));
  endtask

  task automatic do_store(input string req);
    pulse(0, 1, 0, '0);
    chk(op_done == 1'b1 && op_fault == 1'b0, req, 512'({op_done, op_fault}), 512'(2'b10));
    chk(store_image == exp_img, req, store_image, exp_img);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs at reset
    chk({op_done, op_fault, zero_all, configured} == 4'b0, "R9 reset flags",
        512'({op_done, op_fault, zero_all, configured}), 512'(0));
    chk(store_image == '0 && tile_rows_o == '0 && tile_bpr_o == '0 && palette_o == '0,
        "R9 reset data", store_image, '0);
    @(negedge clk); rst = 0;

    // R6: store before any configuration returns zeros
    do_store("R6 unconfigured store");

    // table walk: R1 R2 R3 R4 R5 R10
    for (int i = 0; i < NV; i++) begin
      logic [511:0] img;
      bit acc;
      img = mk_img(VECS[i]);
      acc = !VECS[i].fault;
      pulse(1, 0, 0, img);
      chk(op_done == 1'b1, "R2 done on load", 512'(op_done), 512'(1));
      chk(op_fault == VECS[i].fault, "R3 fault verdict", 512'(op_fault), 512'(VECS[i].fault));
      chk(zero_all == (acc && VECS[i].pal == 0), "R5 zero strobe", 512'(zero_all),
          512'(acc && VECS[i].pal == 0));
      if (acc) begin
        if (VECS[i].pal == 0) begin exp_img = '0; exp_cfg = 0; end
        else begin exp_img = img; exp_cfg = 1; end
      end
      chk(palette_o == exp_img[7:0], "R4 palette held or set", 512'(palette_o), 512'(exp_img[7:0]));
      chk_shape(acc ? "R2 R10 shape" : "R4 shape kept");
      @(negedge clk);
      chk({op_done, op_fault, zero_all} == 3'b0, "R9 single pulse",
          512'({op_done, op_fault, zero_all}), 512'(0));
      do_store("R1 R6 store image");
    end

    // R7: release after a live configuration
    chk(exp_cfg == 1'b1, "R7 precondition", 512'(exp_cfg), 512'(1));
    pulse(0, 0, 1, '0);
    exp_img = '0; exp_cfg = 0;
    chk(zero_all && op_done && !op_fault, "R7 release strobes",
        512'({zero_all, op_done, op_fault}), 512'(3'b110));
    chk_shape("R7 release clears");
    do_store("R7 store after release");

    // R8: release beats load in the same cycle
    pulse(1, 0, 1, mk_img(VECS[0]));
    chk(zero_all == 1'b1, "R8 release wins", 512'(zero_all), 512'(1));
    chk_shape("R8 load ignored");

    // R8: load beats store; store_image must hold its previous value (R6)
    pulse(1, 1, 0, mk_img(VECS[0]));
    exp_cfg = 1;
    chk(configured == 1'b1, "R8 load taken", 512'(configured), 512'(1));
    chk(store_image == '0, "R8 R6 store ignored", store_image, '0);
    exp_img = mk_img(VECS[0]);
    do_store("R6 store after coincident load");

    // R8: load and release plus store all at once -> release
    pulse(1, 1, 1, mk_img(VECS[9]));
    exp_cfg = 0;
    chk(zero_all == 1'b1 && configured == 1'b0, "R8 triple request",
        512'({zero_all, configured}), 512'(2'b10));
    chk(store_image == mk_img(VECS[0]), "R8 store held", store_image, mk_img(VECS[0]));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule